// File: doc/BRIEF.md
# Transmit Descriptor Ring Sequencer

This block walks a ring of transmit buffer descriptors kept in its own register array and hands each ready buffer to a downstream frame builder. Each descriptor has a length, a status field and six flags: ready, last, interrupt, pad, CRC and wrap. Software fills a descriptor through a write port and reads it back through a read port. While transmission is enabled and nothing is in flight, the sequencer checks the current descriptor once per poll interval, counted in serial-clock ticks. A demand request forces the check on the next clock.

A buffer is offered to the builder with a valid/done handshake. When the builder reports completion, the ready flag of that buffer is cleared. If the buffer ends a frame, the builder's frame status is stored in it. An interrupt pulse is raised when the descriptor asks for one. A collision sends the sequencer back to the first descriptor of the frame for a retry.

A graceful-stop command halts the sequencer at the next frame boundary, or at once if no frame is open. A restart command resumes transmission.

Top module: `tx_bd_poller`

## Requirements
- R1: While `tx_en` is high and no buffer is in flight, the current descriptor is checked once every POLL (default 128) `ser_tick` pulses. The first check falls on the POLL-th tick after enable or after the previous check. No check is made while `tx_en` is low or no ticks arrive.
- R2: A one-cycle `demand` pulse while idle and enabled checks the current descriptor at that clock edge, so `buf_valid` is high in the following cycle when the descriptor is ready.
- R3: Descriptor flag bits on `dw_flags`/`dr_flags` are: bit0 ready, bit1 last, bit2 interrupt, bit3 pad, bit4 CRC, bit5 wrap. A ready descriptor is offered with `buf_valid` together with its index, length, last, pad and CRC values. On a `buf_done` without collision for a buffer whose last flag is clear, only its ready flag is cleared; its status is unchanged. The sequencer then moves to the next descriptor and checks it on the following cycle.
- R4: On a `buf_done` without collision for a buffer whose last flag is set, `fr_status` is stored as that descriptor's status and its ready flag is cleared. The next frame starts at the following descriptor.
- R5: `irq` is a one-cycle pulse in the cycle after a buffer completes without collision, and only when that descriptor's interrupt flag is set. A collided buffer raises no interrupt.
- R6: A `buf_done` with `buf_coll` high returns the current index to the first descriptor of the frame and leaves the collided buffer's ready flag set. The frame is offered again even though the ready flags of its earlier buffers were already cleared.
- R7: After a buffer whose wrap flag is set, the next index is 0. After descriptor NDESC-1 the index also returns to 0.
- R8: `gstop_cmd` while idle at a frame boundary makes `gsc` high in the next cycle. Otherwise the sequencer halts once the current frame's last buffer completes, or once a buffer of the frame collides. While halted no buffer is offered, even on demand.
- R9: `restart_cmd` while halted clears `gsc` in the next cycle and checks the current descriptor one cycle later. A frame that was cut off by a collision is retransmitted from its first descriptor.
- R10: After reset every descriptor reads as all-zero, the index is 0, and `buf_valid`, `irq` and `gsc` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| ser_tick | input | 1 | One pulse per serial-clock period |
| demand | input | 1 | Immediate descriptor check request |
| gstop_cmd | input | 1 | Graceful stop command pulse |
| restart_cmd | input | 1 | Restart command pulse |
| dw_en | input | 1 | Descriptor write strobe |
| dw_idx | input | IW | Descriptor write index |
| dw_flags | input | 6 | Flags to write (see R3) |
| dw_len | input | LW | Buffer length to write |
| dr_idx | input | IW | Descriptor read index |
| dr_flags | output | 6 | Flags of descriptor dr_idx |
| dr_len | output | LW | Length of descriptor dr_idx |
| dr_status | output | SW | Status of descriptor dr_idx |
| buf_valid | output | 1 | A buffer is offered to the builder |
| buf_idx | output | IW | Index of the offered buffer |
| buf_len | output | LW | Length of the offered buffer |
| buf_last | output | 1 | Offered buffer ends a frame |
| buf_pad | output | 1 | Pad request of the offered buffer |
| buf_crc | output | 1 | CRC append request of the offered buffer |
| buf_done | input | 1 | Builder finished the offered buffer |
| buf_coll | input | 1 | The finish ended in a collision |
| fr_status | input | SW | Frame status reported with done |
| irq | output | 1 | Completion interrupt pulse |
| gsc | output | 1 | Graceful stop complete |
| cur_idx | output | IW | Current descriptor index |

## Verification
The bench sweeps every interrupt pattern over frames of one to three buffers. The ring wraps several times during the sweep. Each buffer's ready flag, status and interrupt are checked against values the bench derives itself; a design that stored status on non-last buffers or left ready set would fail here.

The poll interval is timed to the exact cycle, so a counter that is off by one, or that kept running while disabled, is caught. A collision in mid-frame must rewind to the first buffer and still offer it with its ready flag already clear; a design that rechecked ready would stall.

Graceful stop is tried while idle, in mid-frame ending normally, and in mid-frame ending in a collision. A design that halted in mid-frame, or that never halted after a collision, fails these checks.

// File: rtl/tx_bd_poller.sv
module tx_bd_poller #(
  parameter int NDESC = 8,
  parameter int POLL  = 128,
  parameter int LW    = 16,
  parameter int SW    = 4,
  localparam int IW   = $clog2(NDESC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          ser_tick,
  input  logic          demand,
  input  logic          gstop_cmd,
  input  logic          restart_cmd,
  input  logic          dw_en,
  input  logic [IW-1:0] dw_idx,
  input  logic [5:0]    dw_flags,
  input  logic [LW-1:0] dw_len,
  input  logic [IW-1:0] dr_idx,
  output logic [5:0]    dr_flags,
  output logic [LW-1:0] dr_len,
  output logic [SW-1:0] dr_status,
  output logic          buf_valid,
  output logic [IW-1:0] buf_idx,
  output logic [LW-1:0] buf_len,
  output logic          buf_last,
  output logic          buf_pad,
  output logic          buf_crc,
  input  logic          buf_done,
  input  logic          buf_coll,
  input  logic [SW-1:0] fr_status,
  output logic          irq,
  output logic          gsc,
  output logic [IW-1:0] cur_idx
);
  localparam int PCW = $clog2(POLL + 1);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_HALT} st_t;

  st_t             st;
  logic [NDESC-1:0] rdy, lst, ien, pdf, crf, wrp;
  logic [LW-1:0]   blen [NDESC];
  logic [SW-1:0]   bsts [NDESC];
  logic [IW-1:0]   cur, first;
  logic [PCW-1:0]  pcnt;
  logic            kick, stop_pend, retry, irq_q;

  wire poll_due  = ser_tick && (pcnt == PCW'(POLL - 1));
  wire poll_now  = tx_en && (st == S_IDLE) && (kick || demand || poll_due);
  wire halt_now  = gstop_cmd && !restart_cmd && (cur == first);
  wire take      = poll_now && (rdy[cur] || retry);
  wire fin       = (st == S_SEND) && buf_done;
  wire ok        = fin && !buf_coll;
  wire stop_here = (stop_pend || gstop_cmd) && !restart_cmd && (buf_coll || lst[cur]);
  wire [IW-1:0] nxt = (wrp[cur] || cur == IW'(NDESC - 1)) ? '0 : cur + 1'b1;

  assign buf_valid = (st == S_SEND);
  assign buf_idx   = cur;
  assign buf_len   = blen[cur];
  assign buf_last  = lst[cur];
  assign buf_pad   = pdf[cur];
  assign buf_crc   = crf[cur];
  assign irq       = irq_q;
  assign gsc       = (st == S_HALT);
  assign cur_idx   = cur;
  assign dr_flags  = {wrp[dr_idx], crf[dr_idx], pdf[dr_idx], ien[dr_idx], lst[dr_idx], rdy[dr_idx]};
  assign dr_len    = blen[dr_idx];
  assign dr_status = bsts[dr_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy <= '0; lst <= '0; ien <= '0; pdf <= '0; crf <= '0; wrp <= '0;
      for (int i = 0; i < NDESC; i++) begin
        blen[i] <= '0;
        bsts[i] <= '0;
      end
    end else begin
      if (dw_en) begin
        rdy[dw_idx]  <= dw_flags[0];
        lst[dw_idx]  <= dw_flags[1];
        ien[dw_idx]  <= dw_flags[2];
        pdf[dw_idx]  <= dw_flags[3];
        crf[dw_idx]  <= dw_flags[4];
        wrp[dw_idx]  <= dw_flags[5];
        blen[dw_idx] <= dw_len;
      end
      if (ok) begin
        rdy[cur] <= 1'b0;
        if (lst[cur]) bsts[cur] <= fr_status;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cur <= '0; first <= '0; pcnt <= '0;
      kick <= 1'b0; stop_pend <= 1'b0; retry <= 1'b0; irq_q <= 1'b0;
    end else begin
      irq_q <= ok && ien[cur];
      if (!tx_en || st != S_IDLE || poll_now) pcnt <= '0;
      else if (ser_tick) pcnt <= pcnt + 1'b1;
      if (poll_now) kick <= 1'b0;
      if (restart_cmd) stop_pend <= 1'b0;
      case (st)
        S_IDLE: begin
          if (halt_now) st <= S_HALT;
          else begin
            if (gstop_cmd && !restart_cmd) stop_pend <= 1'b1;
            if (take) st <= S_SEND;
          end
        end
        S_SEND: begin
          if (fin) begin
            kick <= 1'b1;
            if (buf_coll) begin
              cur   <= first;
              retry <= 1'b1;
            end else begin
              cur <= nxt;
              if (lst[cur]) begin
                first <= nxt;
                retry <= 1'b0;
              end
            end
            if (stop_here) begin
              st <= S_HALT;
              stop_pend <= 1'b0;
            end else st <= S_IDLE;
          end else if (gstop_cmd && !restart_cmd) stop_pend <= 1'b1;
        end
        S_HALT: begin
          if (restart_cmd) begin
            st   <= S_IDLE;
            kick <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_poll_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_valid) |-> $past(kick || demand || ser_tick));

  a_r2_demand: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && st == S_IDLE && demand && rdy[cur] && !gstop_cmd && !restart_cmd) |=> buf_valid);

  a_r3_ready_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ok |=> !rdy[$past(cur)]);

  a_r4_status_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && lst[cur]) |=> bsts[$past(cur)] == $past(fr_status));

  a_r5_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !(ien[cur] && !buf_coll)) |=> !irq);

  a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ok));

  a_r6_coll_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && buf_coll) |=> (cur_idx == $past(first)));

  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && wrp[cur]) |=> (cur_idx == '0));

  a_r8_stay_halted: assert property (@(posedge clk) disable iff (!rst_n)
    (gsc && !restart_cmd) |=> (gsc && !buf_valid));

  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (gsc && restart_cmd) |=> !gsc);
endmodule

// File: tb/tx_bd_poller_bench.sv
module tx_bd_poller_bench;
  localparam int CLK_P = 10;
  localparam int ND    = 8;
  localparam int POLL  = 128;
  localparam int LW    = 16;
  localparam int SW    = 4;
  localparam int IW    = 3;
  localparam logic [5:0] RDY = 6'd1, LST = 6'd2, INT = 6'd4, PAD = 6'd8, CRC = 6'd16, WRP = 6'd32;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst_n, tx_en, ser_tick, demand, gstop_cmd, restart_cmd, dw_en, buf_done, buf_coll;
  logic [IW-1:0] dw_idx, dr_idx;
  logic [5:0]    dw_flags;
  logic [LW-1:0] dw_len;
  logic [SW-1:0] fr_status;
  logic [5:0]    dr_flags;
  logic [LW-1:0] dr_len, buf_len;
  logic [SW-1:0] dr_status;
  logic          buf_valid, buf_last, buf_pad, buf_crc, irq, gsc;
  logic [IW-1:0] buf_idx, cur_idx;

  tx_bd_poller u_tx_bd_poller (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .ser_tick(ser_tick), .demand(demand),
    .gstop_cmd(gstop_cmd), .restart_cmd(restart_cmd), .dw_en(dw_en), .dw_idx(dw_idx),
    .dw_flags(dw_flags), .dw_len(dw_len), .dr_idx(dr_idx), .dr_flags(dr_flags),
    .dr_len(dr_len), .dr_status(dr_status), .buf_valid(buf_valid), .buf_idx(buf_idx),
    .buf_len(buf_len), .buf_last(buf_last), .buf_pad(buf_pad), .buf_crc(buf_crc),
    .buf_done(buf_done), .buf_coll(buf_coll), .fr_status(fr_status), .irq(irq),
    .gsc(gsc), .cur_idx(cur_idx)
  );

  int total = 0, bad = 0;
  logic [SW-1:0] exp_st [ND];

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [5:0] f, int len);
    @(negedge clk);
    dw_en = 1'b1; dw_idx = idx[IW-1:0]; dw_flags = f; dw_len = len[LW-1:0];
    @(negedge clk);
    dw_en = 1'b0;
  endtask

  task automatic pulse_demand();
    @(negedge clk); demand = 1'b1;
    @(negedge clk); demand = 1'b0;
  endtask

  task automatic pulse_gstop();
    @(negedge clk); gstop_cmd = 1'b1;
    @(negedge clk); gstop_cmd = 1'b0;
  endtask

  task automatic pulse_restart();
    @(negedge clk); restart_cmd = 1'b1;
    @(negedge clk); restart_cmd = 1'b0;
  endtask

  task automatic wait_valid(int exp_idx, string req);
    int n = 0;
    while (!buf_valid && n < 400) begin
      @(negedge clk);
      n++;
    end
    check(req, buf_valid ? int'(buf_idx) : -1, exp_idx);
  endtask

  task automatic finish_buf(int coll, int st, int exp_irq, string req);
    buf_done = 1'b1; buf_coll = coll[0]; fr_status = st[SW-1:0];
    @(negedge clk);
    buf_done = 1'b0; buf_coll = 1'b0;
    check(req, int'(irq), exp_irq);
  endtask

  task automatic read_desc(int idx);
    dr_idx = idx[IW-1:0];
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not end actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int bp, idx, n, st, seen;
    logic [5:0] f;
    rst_n = 1'b0; tx_en = 1'b0; ser_tick = 1'b0; demand = 1'b0; gstop_cmd = 1'b0;
    restart_cmd = 1'b0; dw_en = 1'b0; dw_idx = '0; dw_flags = '0; dw_len = '0;
    dr_idx = '0; buf_done = 1'b0; buf_coll = 1'b0; fr_status = '0;
    for (int i = 0; i < ND; i++) exp_st[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 buf_valid", int'(buf_valid), 0);
    check("R10 irq", int'(irq), 0);
    check("R10 gsc", int'(gsc), 0);
    check("R10 cur_idx", int'(cur_idx), 0);
    for (int i = 0; i < ND; i++) begin
      read_desc(i);
      check($sformatf("R10 desc %0d", i), int'({dr_flags, dr_status}) + int'(dr_len), 0);
    end

    // R1 no polling while disabled
    wr(0, RDY | LST | INT, 60);
    ser_tick = 1'b1;
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (buf_valid) seen = 1;
    end
    check("R1 disabled no poll", seen, 0);

    // R1 first poll after POLL ticks
    tx_en = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!buf_valid && n < 400);
    check("R1 poll interval", n, POLL);
    check("R1 poll idx", int'(buf_idx), 0);
    check("R3 len", int'(buf_len), 60);
    ser_tick = 1'b0;
    finish_buf(0, 5, 1, "R5 irq set");
    exp_st[0] = 4'd5;
    read_desc(0);
    check("R4 status", int'(dr_status), 5);
    check("R4 ready cleared", int'(dr_flags[0]), 0);

    // R1 no ticks no poll, then second interval
    wr(1, RDY | LST, 61);
    repeat (200) @(negedge clk);
    check("R1 no ticks no poll", int'(buf_valid), 0);
    ser_tick = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!buf_valid && n < 400);
    check("R1 second interval", n, POLL);
    ser_tick = 1'b0;
    check("R1 idx", int'(buf_idx), 1);
    finish_buf(0, 6, 0, "R5 irq clear");
    exp_st[1] = 4'd6;

    // R2 demand
    wr(2, RDY | LST, 62);
    pulse_demand();
    check("R2 demand latency", int'(buf_valid), 1);
    check("R2 demand idx", int'(buf_idx), 2);
    finish_buf(0, 7, 0, "R5 irq clear");
    exp_st[2] = 4'd7;

    // R3 R4 R5 R7 sweep of frames
    bp = 3;
    for (int nb = 1; nb <= 3; nb++) begin
      for (int ip = 0; ip < (1 << nb); ip++) begin
        for (int i = 0; i < nb; i++) begin
          idx = (bp + i) % ND;
          f = RDY | ((i == nb - 1) ? LST : 6'd0) | (((ip >> i) & 1) != 0 ? INT : 6'd0)
              | ((i == 0) ? PAD : 6'd0) | (((nb + ip) & 1) != 0 ? CRC : 6'd0);
          wr(idx, f, 64 + nb * 8 + i);
        end
        pulse_demand();
        for (int i = 0; i < nb; i++) begin
          idx = (bp + i) % ND;
          wait_valid(idx, "R3 order R7 ring wrap");
          check("R3 len", int'(buf_len), 64 + nb * 8 + i);
          check("R3 last", int'(buf_last), (i == nb - 1) ? 1 : 0);
          check("R3 pad", int'(buf_pad), (i == 0) ? 1 : 0);
          check("R3 crc", int'(buf_crc), (nb + ip) & 1);
          st = (nb * 3 + ip + i) & 15;
          finish_buf(0, st, (ip >> i) & 1, "R5 irq pattern");
          if (i == nb - 1) exp_st[idx] = st[SW-1:0];
          read_desc(idx);
          check("R3 R4 ready cleared", int'(dr_flags[0]), 0);
          check("R3 R4 status", int'(dr_status), int'(exp_st[idx]));
        end
        bp = (bp + nb) % ND;
      end
    end

    // R7 wrap flag
    wr(bp, RDY | WRP, 10);
    wr(0, RDY | LST, 11);
    pulse_demand();
    wait_valid(bp, "R7 before wrap");
    finish_buf(0, 1, 0, "R5");
    wait_valid(0, "R7 wrap flag");
    finish_buf(0, 2, 0, "R5");
    exp_st[0] = 4'd2;
    bp = 1;

    // R6 collision in mid-frame
    wr(1, RDY, 20);
    wr(2, RDY, 21);
    wr(3, RDY | LST | INT, 22);
    pulse_demand();
    wait_valid(1, "R6 start");
    finish_buf(0, 3, 0, "R5");
    wait_valid(2, "R6 second");
    finish_buf(1, 3, 0, "R5 R6 no irq on collision");
    read_desc(2);
    check("R6 ready kept", int'(dr_flags[0]), 1);
    check("R6 cur rewind", int'(cur_idx), 1);
    wait_valid(1, "R6 retransmit first");
    finish_buf(0, 3, 0, "R5");
    wait_valid(2, "R6 retransmit second");
    finish_buf(0, 3, 0, "R5");
    wait_valid(3, "R6 retransmit last");
    finish_buf(0, 9, 1, "R5");
    read_desc(3);
    check("R4 status after retry", int'(dr_status), 9);
    bp = 4;

    // R8 stop when idle, R9 restart
    pulse_gstop();
    check("R8 idle stop", int'(gsc), 1);
    wr(4, RDY | LST, 30);
    pulse_demand();
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (buf_valid) seen = 1;
    end
    check("R8 halted no offer", seen, 0);
    pulse_restart();
    check("R9 gsc cleared", int'(gsc), 0);
    check("R9 not yet offered", int'(buf_valid), 0);
    @(negedge clk);
    check("R9 immediate check", int'(buf_valid), 1);
    check("R9 idx", int'(buf_idx), 4);
    finish_buf(0, 4, 0, "R5");

    // R8 stop during frame ends at frame boundary
    wr(5, RDY, 31);
    wr(6, RDY | LST, 32);
    pulse_demand();
    wait_valid(5, "R8 frame start");
    pulse_gstop();
    check("R8 no halt mid-frame", int'(gsc), 0);
    finish_buf(0, 4, 0, "R5");
    check("R8 no halt after non-last", int'(gsc), 0);
    wait_valid(6, "R8 frame continues");
    finish_buf(0, 4, 0, "R5");
    check("R8 halt at frame end", int'(gsc), 1);
    check("R8 cur after frame", int'(cur_idx), 7);
    pulse_restart();
    check("R9 gsc cleared", int'(gsc), 0);

    // R8 stop during frame ending in collision, R9 retransmit
    wr(7, RDY, 33);
    wr(0, RDY | LST, 34);
    pulse_demand();
    wait_valid(7, "R8 coll frame start");
    finish_buf(0, 4, 0, "R5");
    wait_valid(0, "R7 natural wrap");
    pulse_gstop();
    finish_buf(1, 4, 0, "R5");
    check("R8 halt on collision", int'(gsc), 1);
    check("R6 R8 rewind", int'(cur_idx), 7);
    pulse_restart();
    check("R9 gsc cleared", int'(gsc), 0);
    wait_valid(7, "R9 retransmit first");
    finish_buf(0, 4, 0, "R5");
    wait_valid(0, "R9 retransmit last");
    finish_buf(0, 12, 0, "R5");
    read_desc(0);
    check("R4 status", int'(dr_status), 12);
    check("R9 running", int'(gsc), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule